// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold and Interrupt Status

This block sits between a serial bus sequencer and the software-facing register interface of a bus controller. It holds two byte queues of 128 entries each: software writes the transmit queue and the sequencer pops it, and the sequencer pushes received bytes that software then pops. Both queues report their fill level.

The receive queue has a programmable high threshold. Software may rewrite it on every service pass. A threshold of one lets software look at a leading length byte before it commits to the rest of a block read. Queue events and sequencer events (address NACK, address acknowledged, data done, arbitration lost, bus error) are latched in a status register. Software clears that register by writing ones to the bits it wants cleared. An enable mask, laid out in the same bit positions, selects which latched bits drive the single interrupt line.

Top module: `fifo_irq_hub`

## Requirements
- R1: Each queue holds up to 128 bytes and returns them in the order they were pushed. `tx_wcnt` and `rx_wcnt` report the current fill (0 to 128) one cycle after the push or pop edge. Read data is valid at `tx_rdata`/`rx_rdata` while the queue is not empty.
- R2: A push into a full queue and a pop from an empty queue are ignored, and the count never wraps. When a full queue sees a push and a pop in the same cycle, only the pop takes effect.
- R3: A write to the control port with `ctl_wdata[16]` = 1 empties both queues in that cycle, and any push or pop in that cycle is ignored. Every control write loads `ctl_wdata[15:8]` as the receive high threshold. A threshold of 0 disables the threshold event.
- R4: Status bit 2 sets on the clock edge where the receive count first becomes greater than or equal to a nonzero threshold. With threshold 1 it sets on the edge that stores the first byte. It does not set again while the count stays at or above the threshold.
- R5: Status bit 3 sets on the edge where a pop takes the transmit count from 1 to 0. A flush does not set it.
- R6: Status bit 4 sets on the edge where the transmit count reaches 128.
- R7: Sequencer pulses set status bits on the edge where they are sampled: `ev_anack` sets bit 25, `ev_aack` sets bit 13, `ev_done` sets bit 12, `ev_arb` sets bit 11, `ev_buserr` sets bit 0. Bits other than 25, 13, 12, 11, 4, 3, 2 and 0 always read 0 in both `ist_q` and `ien_q`.
- R8: A status write with `ist_w1c` = 1 clears each status bit whose `ist_wdata` bit is 1. Status bits written as 0 keep their value.
- R9: If a status bit's event and its write-one-to-clear occur in the same cycle, the bit ends up set.
- R10: `irq` is 1 exactly when some status bit is set and the enable bit at the same position is also set. It follows the registered status and enable values in the same cycle.
- R11: After reset both counts are 0, status and enable are 0, the threshold is 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 9 | Control fields: bit 16 flush, bits 15:8 high threshold |
| tx_push | input | 1 | Software push into transmit queue |
| tx_wdata | input | 8 | Byte to push into transmit queue |
| tx_pop | input | 1 | Sequencer pop from transmit queue |
| tx_rdata | output | 8 | Head of transmit queue |
| rx_push | input | 1 | Sequencer push into receive queue |
| rx_wdata | input | 8 | Byte to push into receive queue |
| rx_pop | input | 1 | Software pop from receive queue |
| rx_rdata | output | 8 | Head of receive queue |
| tx_wcnt | output | 8 | Transmit queue fill |
| rx_wcnt | output | 8 | Receive queue fill |
| ien_wr | input | 1 | Enable mask write strobe |
| ien_wdata | input | 32 | Enable mask value |
| ien_q | output | 32 | Current enable mask |
| ist_w1c | input | 1 | Status write-one-to-clear strobe |
| ist_wdata | input | 32 | Bits to clear |
| ist_q | output | 32 | Latched status |
| ev_anack | input | 1 | Address not acknowledged pulse |
| ev_aack | input | 1 | Address acknowledged pulse |
| ev_done | input | 1 | Data transfer done pulse |
| ev_arb | input | 1 | Arbitration lost pulse |
| ev_buserr | input | 1 | Bus error pulse |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count or pointer shows up on the data head or on `tx_wcnt`/`rx_wcnt` one cycle after the bad push or pop. Because the queues are filled and drained end to end, a wrap or ordering fault appears within one full sweep of 128 bytes. A bad threshold comparison shows as status bit 2 setting one byte early or one byte late, so every threshold in the sweep is checked at each fill level. Mistakes in the status merge show on `ist_q` and `irq` on the very next cycle after the event, clear or mask write that exposes them.

// File: rtl/tfq_pkg.sv
package tfq_pkg;
  localparam int ST_W      = 32;
  localparam int B_BUSERR  = 0;
  localparam int B_HI      = 2;
  localparam int B_EMPTY   = 3;
  localparam int B_FULL    = 4;
  localparam int B_ARB     = 11;
  localparam int B_DONE    = 12;
  localparam int B_AACK    = 13;
  localparam int B_ANACK   = 25;

  localparam logic [ST_W-1:0] IMPL_MASK =
    (ST_W'(1) << B_BUSERR) | (ST_W'(1) << B_HI)   | (ST_W'(1) << B_EMPTY) |
    (ST_W'(1) << B_FULL)   | (ST_W'(1) << B_ARB)  | (ST_W'(1) << B_DONE)  |
    (ST_W'(1) << B_AACK)   | (ST_W'(1) << B_ANACK);

  // sticky merge: clear first, then new events win
  function automatic logic [ST_W-1:0] w1c_merge(input logic [ST_W-1:0] cur,
                                                input logic [ST_W-1:0] clr,
                                                input logic [ST_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign push_ok = push & ~flush & (cnt != CW'(DEPTH));
  assign pop_ok  = pop  & ~flush & (cnt != '0);
  assign cnt_nxt = flush ? '0 : cnt + CW'(push_ok) - CW'(pop_ok);
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
        if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/irq_status.sv
module irq_status
  import tfq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] evt_vec,
  input  logic            ien_wr,
  input  logic [ST_W-1:0] ien_wdata,
  input  logic            ist_w1c,
  input  logic [ST_W-1:0] ist_wdata,
  output logic [ST_W-1:0] ien_q,
  output logic [ST_W-1:0] ist_q,
  output logic            irq
);
  logic [ST_W-1:0] clr_vec;

  assign clr_vec = ist_w1c ? ist_wdata : '0;
  assign irq     = |(ist_q & ien_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q <= '0;
      ist_q <= '0;
    end else begin
      if (ien_wr) ien_q <= ien_wdata & IMPL_MASK;
      ist_q <= w1c_merge(ist_q, clr_vec, evt_vec & IMPL_MASK);
    end
  end
endmodule

// File: rtl/fifo_irq_hub.sv
module fifo_irq_hub
  import tfq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int THR_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr,
  input  logic [16:8]     ctl_wdata,
  input  logic            tx_push,
  input  logic [7:0]      tx_wdata,
  input  logic            tx_pop,
  output logic [7:0]      tx_rdata,
  input  logic            rx_push,
  input  logic [7:0]      rx_wdata,
  input  logic            rx_pop,
  output logic [7:0]      rx_rdata,
  output logic [CW-1:0]   tx_wcnt,
  output logic [CW-1:0]   rx_wcnt,
  input  logic            ien_wr,
  input  logic [ST_W-1:0] ien_wdata,
  output logic [ST_W-1:0] ien_q,
  input  logic            ist_w1c,
  input  logic [ST_W-1:0] ist_wdata,
  output logic [ST_W-1:0] ist_q,
  input  logic            ev_anack,
  input  logic            ev_aack,
  input  logic            ev_done,
  input  logic            ev_arb,
  input  logic            ev_buserr,
  output logic            irq
);
  logic              flush;
  logic [THR_W-1:0]  hi_thr;
  logic [CW-1:0]     tx_cnt_nxt, rx_cnt_nxt;
  logic              hi_now, hi_armed;
  logic              hi_evt, empty_evt, full_evt;
  logic [ST_W-1:0]   evt_vec;

  function automatic logic hi_reached(input logic [CW-1:0] c,
                                      input logic [THR_W-1:0] t);
    return (t != '0) && (int'(c) >= int'(t));
  endfunction

  assign flush = ctl_wr & ctl_wdata[16];

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_rdata), .cnt(tx_wcnt), .cnt_nxt(tx_cnt_nxt)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .rdata(rx_rdata), .cnt(rx_wcnt), .cnt_nxt(rx_cnt_nxt)
  );

  // queue events are taken from the count that the coming edge stores
  assign hi_now    = hi_reached(rx_cnt_nxt, hi_thr);
  assign hi_evt    = hi_now & ~hi_armed;
  assign empty_evt = ~flush & (tx_wcnt != '0) & (tx_cnt_nxt == '0);
  assign full_evt  = (tx_wcnt != CW'(DEPTH)) & (tx_cnt_nxt == CW'(DEPTH));

  always_comb begin
    evt_vec            = '0;
    evt_vec[B_HI]      = hi_evt;
    evt_vec[B_EMPTY]   = empty_evt;
    evt_vec[B_FULL]    = full_evt;
    evt_vec[B_BUSERR]  = ev_buserr;
    evt_vec[B_ARB]     = ev_arb;
    evt_vec[B_DONE]    = ev_done;
    evt_vec[B_AACK]    = ev_aack;
    evt_vec[B_ANACK]   = ev_anack;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_thr   <= '0;
      hi_armed <= 1'b0;
    end else begin
      if (ctl_wr) hi_thr <= ctl_wdata[15:8];
      hi_armed <= hi_now;
    end
  end

  irq_status u_irq (
    .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .ist_w1c(ist_w1c), .ist_wdata(ist_wdata),
    .ien_q(ien_q), .ist_q(ist_q), .irq(irq)
  );
endmodule

// File: rtl/fifo_irq_hub_chk.sv
module fifo_irq_hub_chk
  import tfq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CW    = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic [CW-1:0]   tx_wcnt,
  input logic [CW-1:0]   rx_wcnt,
  input logic [ST_W-1:0] evt_vec,
  input logic            ist_w1c,
  input logic [ST_W-1:0] ist_wdata,
  input logic [ST_W-1:0] ist_q,
  input logic [ST_W-1:0] ien_q,
  input logic            irq
);
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_wcnt) <= DEPTH) && (int'(rx_wcnt) <= DEPTH));

  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flush) |-> ((int'(tx_wcnt) - int'($past(tx_wcnt)) <= 1) &&
                       (int'($past(tx_wcnt)) - int'(tx_wcnt) <= 1) &&
                       (int'(rx_wcnt) - int'($past(rx_wcnt)) <= 1) &&
                       (int'($past(rx_wcnt)) - int'(rx_wcnt) <= 1)));

  assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_wcnt == '0) && (rx_wcnt == '0));

  assert_unused_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ist_q & ~IMPL_MASK) == '0) && ((ien_q & ~IMPL_MASK) == '0));

  assert_keep_uncleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ist_q & $past(ist_q & ~(ist_w1c ? ist_wdata : '0))) ==
              $past(ist_q & ~(ist_w1c ? ist_wdata : '0))));

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_vec & IMPL_MASK) != '0) |=> ((ist_q & $past(evt_vec & IMPL_MASK)) ==
                                       $past(evt_vec & IMPL_MASK)));

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ien_q == '0) || (ist_q == '0)) |-> !irq);
endmodule

bind fifo_irq_hub fifo_irq_hub_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .tx_wcnt(tx_wcnt), .rx_wcnt(rx_wcnt), .evt_vec(evt_vec),
  .ist_w1c(ist_w1c), .ist_wdata(ist_wdata),
  .ist_q(ist_q), .ien_q(ien_q), .irq(irq)
);

// File: tb/tb_fifo_irq_hub.sv
`timescale 1ns/1ps
module tb_fifo_irq_hub;
  localparam int D = 128;
  localparam logic [31:0] IMPL = 32'h0200_381D; // bits 25,13,12,11,4,3,2,0

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0; logic [16:8] ctl_wdata = '0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata, tx_wcnt, rx_wcnt;
  logic ien_wr = 0, ist_w1c = 0;
  logic [31:0] ien_wdata = '0, ist_wdata = '0, ien_q, ist_q;
  logic ev_anack = 0, ev_aack = 0, ev_done = 0, ev_arb = 0, ev_buserr = 0, irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fifo_irq_hub dut (.*);

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_all();
    ist_w1c = 1; ist_wdata = 32'hFFFF_FFFF; tick(); ist_w1c = 0;
  endtask

  task automatic pulse_ev(input int k);
    case (k)
      0: ev_anack = 1; 1: ev_aack = 1; 2: ev_done = 1; 3: ev_arb = 1; default: ev_buserr = 1;
    endcase
    tick();
    {ev_anack, ev_aack, ev_done, ev_arb, ev_buserr} = '0;
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int thr_list[4] = '{1, 2, 5, 128};
    int ev_pos[5]   = '{25, 13, 12, 11, 0};
    repeat (3) tick();
    rst_n = 1; tick();
    // R11 reset state
    chk("R11 tx_wcnt", 32'(tx_wcnt), 0);
    chk("R11 rx_wcnt", 32'(rx_wcnt), 0);
    chk("R11 ist", ist_q, 0);
    chk("R11 ien", ien_q, 0);
    chk("R11 irq", 32'(irq), 0);

    // R7 only implemented enable bits stick
    ien_wr = 1; ien_wdata = 32'hFFFF_FFFF; tick(); ien_wr = 0;
    chk("R7 ien mask", ien_q, IMPL);
    chk("R10 irq no status", 32'(irq), 0);

    // R1/R6 fill transmit queue
    for (int i = 0; i < D; i++) begin
      tx_push = 1; tx_wdata = pat(i); tick();
      chk("R1 tx fill count", 32'(tx_wcnt), 32'(i + 1));
      chk("R6 full bit", 32'(ist_q[4]), 32'(i == D - 1));
    end
    chk("R10 irq on full", 32'(irq), 1);
    tx_wdata = 8'hFF; tick();
    chk("R2 push to full ignored", 32'(tx_wcnt), D);
    // R2 push+pop at full: only pop
    chk("R1 tx head", 32'(tx_rdata), 32'(pat(0)));
    tx_pop = 1; tx_wdata = 8'hEE; tick(); tx_push = 0; tx_pop = 0;
    chk("R2 push+pop at full", 32'(tx_wcnt), D - 1);
    clear_all();
    chk("R8 clear all", ist_q, 0);
    chk("R10 irq cleared", 32'(irq), 0);

    // R1/R5 drain
    for (int i = 1; i < D; i++) begin
      chk("R1 tx order", 32'(tx_rdata), 32'(pat(i)));
      tx_pop = 1; tick();
      chk("R1 tx drain count", 32'(tx_wcnt), 32'(D - 1 - i));
      chk("R5 empty bit", 32'(ist_q[3]), 32'(i == D - 1));
    end
    tick(); tx_pop = 0;
    chk("R2 pop empty ignored", 32'(tx_wcnt), 0);
    chk("R5 empty held", 32'(ist_q[3]), 1);

    // R7 events, R8 partial clear
    ev_done = 1; ev_buserr = 1; tick(); ev_done = 0; ev_buserr = 0;
    chk("R7 done+buserr", ist_q, 32'h0000_1009);
    ist_w1c = 1; ist_wdata = 32'h8; tick(); ist_w1c = 0;
    chk("R8 zeros keep", ist_q, 32'h0000_1001);
    for (int k = 0; k < 5; k++) begin
      clear_all();
      pulse_ev(k);
      chk("R7 event bit", ist_q, 32'h1 << ev_pos[k]);
    end

    // R9 set wins over clear
    clear_all();
    ev_done = 1; ist_w1c = 1; ist_wdata = 32'h1000; tick(); ev_done = 0; ist_w1c = 0;
    chk("R9 set wins", ist_q, 32'h1000);

    // R10 mask
    ien_wr = 1; ien_wdata = 32'h1000; tick();
    chk("R10 enabled irq", 32'(irq), 1);
    ien_wdata = ~32'h1000; tick(); ien_wr = 0;
    chk("R10 masked irq", 32'(irq), 0);

    // R4 threshold sweep, R1 receive order
    foreach (thr_list[t]) begin
      int thr = thr_list[t];
      ctl_wr = 1; ctl_wdata = {1'b1, 8'(thr)}; tick(); ctl_wr = 0;
      clear_all();
      for (int n = 1; n <= thr; n++) begin
        rx_push = 1; rx_wdata = pat(n + t); tick(); rx_push = 0;
        chk("R4 hi bit at count", 32'(ist_q[2]), 32'(n >= thr));
      end
      chk("R1 rx count", 32'(rx_wcnt), 32'(thr));
      if (thr < D) begin
        clear_all();
        rx_push = 1; rx_wdata = pat(thr + 1 + t); tick(); rx_push = 0;
        chk("R4 no refire above", 32'(ist_q[2]), 0);
      end
      for (int n = 1; n <= thr + (thr < D ? 1 : 0); n++) begin
        chk("R1 rx order", 32'(rx_rdata), 32'(pat(n + t)));
        rx_pop = 1; tick(); rx_pop = 0;
      end
      chk("R1 rx drained", 32'(rx_wcnt), 0);
    end

    // R3 flush, R5 no empty on flush
    for (int i = 0; i < 3; i++) begin
      tx_push = 1; rx_push = 1; tx_wdata = pat(i); rx_wdata = pat(i); tick();
    end
    tx_push = 0; rx_push = 0;
    clear_all();
    ctl_wr = 1; ctl_wdata = {1'b1, 8'd0}; rx_push = 1; tick(); ctl_wr = 0; rx_push = 0;
    chk("R3 flush tx", 32'(tx_wcnt), 0);
    chk("R3 flush rx with push", 32'(rx_wcnt), 0);
    chk("R5 flush no empty", 32'(ist_q[3]), 0);
    rx_push = 1; rx_wdata = 8'h42; tick(); rx_push = 0;
    chk("R3 thr zero disables", 32'(ist_q[2]), 0);
    chk("R1 rx after flush", 32'(rx_rdata), 32'h42);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule